// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Trigger

This block decides when each new switching cycle of a quasi-resonant flyback controller begins. It watches a valley-detect signal from an external comparator. It issues a one-clock start pulse that tells the downstream gate-drive logic to begin the next on-time. The aim is to switch at a ringing valley of the drain voltage while keeping the switching period above a minimum. When no valley appears in time, a fallback or a watchdog forces the next start instead.

After each start a blanking window holds off all valleys. The first valley after the window starts the next cycle. If a valley was seen during blanking and none follows, a short fallback delay forces the start once the window has closed. If no valley is seen for a long time, a starter timer forces the start. Each of these durations is a parameter counted in clock cycles. By default it is derived from a clock-frequency parameter and a nominal time in nanoseconds: 8500 ns for blanking, 5000 ns for the fallback and 31900 ns for the starter. Each start pulse carries a registered code that names its cause.

Top module: `qrv_valley_trigger`

## Requirements
- R1: `start_o` is never high for two cycles in a row. `cause_o` changes only with a start pulse and then holds its value. The codes are: 2'b01 for a valley, 2'b10 for the fallback, 2'b11 for the starter, and 2'b00 only after reset.
- R2: Let cycle 0 be the cycle in which `start_o` is high. A valley detected in cycles 0 to BLANK_CYC-1 never causes a start. The shortest period is therefore BLANK_CYC+1 cycles.
- R3: A valley edge in which `valley_i` is first sampled high d clock edges after a start pulse is detected in cycle d+1. If d+1 >= BLANK_CYC, `start_o` rises d+2 cycles after the previous start pulse, with cause 2'b01.
- R4: Suppose a valley was detected during blanking and no valley follows. Then the next start pulse comes exactly BLANK_CYC+FALLBACK_CYC cycles after the previous one, with cause 2'b10.
- R5: If no valley starts a cycle, the next start pulse comes exactly STARTER_CYC cycles after the previous one, with cause 2'b11.
- R6: Every start pulse clears all timers and the record of a blanking valley. A valley during blanking in one period does not arm the fallback in the next period.
- R7: `valley_i` passes through a two-flop synchronizer and a rising-edge detector. An input held high across many cycles counts as one valley.
- R8: If a valley is detected in the same cycle that the fallback or starter expires, exactly one start pulse is produced, and its cause is 2'b01.
- R9: No start pulse is produced while `en_i` is low. The first start after `en_i` returns high comes from the starter, STARTER_CYC cycles after the last edge that sampled `en_i` low. Valleys are ignored until that start.
- R10: While `rst_n` is low, `start_o` is 0 and `cause_o` is 2'b00. After release, the first start comes from the starter, STARTER_CYC cycles after the last edge in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Switching enable; low halts all start pulses |
| valley_i | input | 1 | Valley-detect level from the external comparator |
| start_o | output | 1 | One-cycle start of the next switching cycle |
| cause_o | output | 2 | Cause of the most recent start (01 valley, 10 fallback, 11 starter) |

## Verification
The hardest situation to reach is a valley edge that lands in exactly the cycle in which an armed fallback or the starter expires. Two subtractions sit in the way: the valley passes through a three-register input path, and the timer counts from the start pulse. The bench therefore places valley pulses by their offset in drive cycles from the last observed start, using offsets computed from the parameters. This hits that cycle and the two edges of the blanking window. A seeded random phase then mixes valleys of random width and spacing with short enable drops, and every cycle is compared against a cycle-level reference model of the requirements.

// File: rtl/qrv_pkg.sv
// Shared types for the quasi-resonant valley trigger.
// Assumes: nothing beyond a 2-bit cause code carried to the top ports.
package qrv_pkg;

    // Reason a switching cycle was started; 00 only after reset.
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_VALLEY   = 2'b01,
        CAUSE_FALLBACK = 2'b10,
        CAUSE_STARTER  = 2'b11
    } cause_e;

endpackage

// File: rtl/qrv_edge_sync.sv
// Synchronizes an asynchronous level through STAGES flops and flags its
// rising edges as single-cycle pulses.
// Assumes: STAGES >= 2; a level held high produces one pulse only.
module qrv_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, first stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= level_i;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the synchronized level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb begin
        rise_o = sync_q[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/qrv_cycle_timer.sv
// Counts clock cycles since the last clear. The count saturates at LIMIT.
// Assumes: clr_i has priority over counting; a cleared count reads 0.
module qrv_cycle_timer #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned LIMIT = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Up-count with clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose the count.
    always_comb begin
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/qrv_trigger_arbiter.sv
// Decides, cycle by cycle, whether a new switching cycle starts and why.
// Priority is valley, then fallback, then starter, so that coincident
// events produce one start.
// Assumes: cnt_i is cycles since the last start (0 in the start cycle);
// BLANK_CYC + FALLBACK_CYC < STARTER_CYC; BLANK_CYC and FALLBACK_CYC >= 1.
module qrv_trigger_arbiter
    import qrv_pkg::*;
#(
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned BLANK_CYC    = 1062,
    parameter int unsigned FALLBACK_CYC = 625,
    parameter int unsigned STARTER_CYC  = 3987
) (
    input  logic             en_i,
    input  logic             primed_i,
    input  logic             armed_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             in_blank_o,
    output logic             fire_o,
    output cause_e           cause_o
);

    localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] FB_HIT  = CNT_W'(BLANK_CYC + FALLBACK_CYC - 1);
    localparam logic [CNT_W-1:0] ST_HIT  = CNT_W'(STARTER_CYC - 1);

    logic valley_go;
    logic fallback_go;
    logic starter_go;

    // Individual trigger conditions.
    always_comb begin
        in_blank_o  = (cnt_i < BLANK_V);
        valley_go   = primed_i & edge_i & ~in_blank_o;
        fallback_go = primed_i & armed_i & (cnt_i == FB_HIT);
        starter_go  = (cnt_i == ST_HIT);
    end

    // Priority selection of a single start and its cause.
    always_comb begin
        fire_o  = 1'b0;
        cause_o = CAUSE_NONE;
        if (en_i) begin
            if (valley_go) begin
                fire_o  = 1'b1;
                cause_o = CAUSE_VALLEY;
            end else if (fallback_go) begin
                fire_o  = 1'b1;
                cause_o = CAUSE_FALLBACK;
            end else if (starter_go) begin
                fire_o  = 1'b1;
                cause_o = CAUSE_STARTER;
            end
        end
    end

endmodule

// File: rtl/qrv_valley_trigger.sv
// Top of the quasi-resonant valley trigger. It starts switching cycles
// on valleys after a blanking window, with a fallback after a blanking
// valley and a long starter timer. Outputs are registered.
// Assumes: valley_i is asynchronous; durations are cycle counts derived
// by default from CLK_MHZ and nominal nanosecond times.
module qrv_valley_trigger
    import qrv_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 125,
    parameter int unsigned BLANK_NS     = 8500,
    parameter int unsigned FALLBACK_NS  = 5000,
    parameter int unsigned STARTER_NS   = 31900,
    parameter int unsigned BLANK_CYC    = CLK_MHZ * BLANK_NS / 1000,
    parameter int unsigned FALLBACK_CYC = CLK_MHZ * FALLBACK_NS / 1000,
    parameter int unsigned STARTER_CYC  = CLK_MHZ * STARTER_NS / 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       valley_i,
    output logic       start_o,
    output logic [1:0] cause_o
);

    localparam int unsigned CNT_W = $clog2(STARTER_CYC + 1);

    logic             vld_edge;
    logic [CNT_W-1:0] since_start;
    logic             tmr_clr;
    logic             in_blank;
    logic             fire;
    cause_e           fire_cause;
    logic             armed_q;
    logic             primed_q;
    logic             start_q;
    cause_e           cause_q;

    qrv_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (valley_i),
        .rise_o  (vld_edge)
    );

    // Timers restart on each start and stay at 0 while disabled.
    always_comb begin
        tmr_clr = fire | ~en_i;
    end

    qrv_cycle_timer #(
        .CNT_W (CNT_W),
        .LIMIT (STARTER_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (since_start)
    );

    qrv_trigger_arbiter #(
        .CNT_W        (CNT_W),
        .BLANK_CYC    (BLANK_CYC),
        .FALLBACK_CYC (FALLBACK_CYC),
        .STARTER_CYC  (STARTER_CYC)
    ) u_arb (
        .en_i       (en_i),
        .primed_i   (primed_q),
        .armed_i    (armed_q),
        .edge_i     (vld_edge),
        .cnt_i      (since_start),
        .in_blank_o (in_blank),
        .fire_o     (fire),
        .cause_o    (fire_cause)
    );

    // Record a valley seen inside blanking; cleared by start or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (tmr_clr) begin
            armed_q <= 1'b0;
        end else if (vld_edge && in_blank && primed_q) begin
            armed_q <= 1'b1;
        end
    end

    // Valleys count only after the first start since reset or enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (!en_i) begin
            primed_q <= 1'b0;
        end else if (fire) begin
            primed_q <= 1'b1;
        end
    end

    // Register the start pulse and hold its cause until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            start_q <= fire;
            if (fire) begin
                cause_q <= fire_cause;
            end
        end
    end

    // Drive the ports.
    always_comb begin
        start_o = start_q;
        cause_o = cause_q;
    end

endmodule

// File: rtl/qrv_valley_trigger_chk.sv
// Protocol checker for qrv_valley_trigger. It keeps its own count of
// cycles since the last start or disable and checks period bounds.
// Assumes: it is bound into every instance of the top module.
module qrv_valley_trigger_chk #(
    parameter int unsigned BLANK_CYC   = 1062,
    parameter int unsigned STARTER_CYC = 3987
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       start_o,
    input logic [1:0] cause_o
);

    localparam int unsigned GAP_W = $clog2(STARTER_CYC + 2);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(STARTER_CYC + 1);

    logic [GAP_W-1:0] gap_q;

    // Cycles since the last start, or since the last disabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!en_i) begin
            gap_q <= '0;
        end else if (start_o) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r1_cause_coded: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cause_o != 2'b00));

    a_r2_min_period: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (gap_q > GAP_W'(BLANK_CYC)));

    a_r5_starter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GAP_W'(STARTER_CYC)) |-> start_o);

    a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !start_o);

endmodule

bind qrv_valley_trigger qrv_valley_trigger_chk #(
    .BLANK_CYC   (BLANK_CYC),
    .STARTER_CYC (STARTER_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .start_o (start_o),
    .cause_o (cause_o)
);

// File: tb/qrv_valley_trigger_test.sv
module qrv_valley_trigger_test;

    localparam int BLANK = 40;
    localparam int FB    = 20;
    localparam int START = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       valley_i = 1'b0;
    logic       start_o;
    logic [1:0] cause_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // reference model state
    logic m_s1 = 0, m_s2 = 0, m_prev = 0;
    int   m_cnt = 0;
    logic m_armed = 0, m_primed = 0, m_start = 0;
    logic [1:0] m_cause = 2'b00;

    qrv_valley_trigger #(
        .BLANK_CYC    (BLANK),
        .FALLBACK_CYC (FB),
        .STARTER_CYC  (START)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .valley_i (valley_i),
        .start_o  (start_o),
        .cause_o  (cause_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic string req_of(input logic [1:0] c);
        case (c)
            2'b01:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance the reference model by one edge with the driven inputs.
    task automatic model_step();
        logic edge_v, fire;
        logic [1:0] c;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0;
            m_armed = 0; m_primed = 0; m_start = 0; m_cause = 2'b00;
        end else begin
            edge_v = m_s2 & ~m_prev;
            fire = 0;
            c = 2'b00;
            if (en_i) begin
                if (m_primed && edge_v && m_cnt >= BLANK) begin fire = 1; c = 2'b01; end
                else if (m_primed && m_armed && m_cnt == BLANK + FB - 1) begin fire = 1; c = 2'b10; end
                else if (m_cnt == START - 1) begin fire = 1; c = 2'b11; end
            end
            if (!en_i || fire) m_armed = 0;
            else if (edge_v && m_primed && m_cnt < BLANK) m_armed = 1;
            if (!en_i) m_primed = 0;
            else if (fire) m_primed = 1;
            if (!en_i || fire) m_cnt = 0;
            else if (m_cnt < START) m_cnt++;
            m_start = fire;
            if (fire) m_cause = c;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = valley_i;
        end
    endtask

    // One clock: sample after the edge, compare against the model.
    task automatic step();
        @(posedge clk);
        #1;
        model_step();
        if (start_o !== m_start)
            check(m_start ? req_of(m_cause) : "R2", int'(start_o), int'(m_start));
        else
            check("R1", int'(start_o), int'(m_start));
        if (cause_o !== m_cause)
            check("R1", int'(cause_o), int'(m_cause));
    endtask

    // From just after a start: valley pulses at offsets d1/d2 (0 = none);
    // returns cycles to the next start and its cause.
    task automatic measure(input int d1, input int w1, input int d2, input int w2,
                           output int per, output logic [1:0] cs);
        per = -1;
        cs = 2'b00;
        for (int k = 1; k <= 400; k++) begin
            valley_i = (d1 > 0 && k >= d1 && k < d1 + w1) ||
                       (d2 > 0 && k >= d2 && k < d2 + w2);
            step();
            if (start_o) begin
                per = k;
                cs = cause_o;
                break;
            end
        end
    endtask

    task automatic expect_period(input string req, input int d1, input int w1,
                                 input int d2, input int w2, input int ep,
                                 input logic [1:0] ec);
        int p;
        logic [1:0] c;
        measure(d1, w1, d2, w2, p, c);
        check(req, p, ep);
        check(req, int'(c), int'(ec));
    endtask

    initial begin
        int p;
        logic [1:0] c;
        void'($urandom(32'h5EED_0042));
        repeat (3) step();
        // R10: reset state
        check("R10", int'(start_o), 0);
        check("R10", int'(cause_o), 0);
        rst_n = 1'b1;
        en_i = 1'b1;
        // R10: first start from the starter; early valleys ignored
        expect_period("R10", 60, 3, 0, 0, START, 2'b11);
        // R5: no valley at all
        expect_period("R5", 0, 0, 0, 0, START, 2'b11);
        // R1: pulse is one cycle, cause held
        valley_i = 1'b0;
        step();
        check("R1", int'(start_o), 0);
        check("R1", int'(cause_o), 3);
        m_start = 0;
        // continue from that extra step: offsets shift by one
        expect_period("R3", 59, 3, 0, 0, 61, 2'b01);
        // R3: valley after blanking
        expect_period("R3", 60, 3, 0, 0, 62, 2'b01);
        // R2: valley detected in the last blanking cycle arms, no start
        expect_period("R2", BLANK - 2, 2, 0, 0, BLANK + FB, 2'b10);
        // R2: first cycle after blanking accepted
        expect_period("R2", BLANK - 1, 2, 0, 0, BLANK + 1, 2'b01);
        // R4: fallback after a blanking valley
        expect_period("R4", 5, 2, 0, 0, BLANK + FB, 2'b10);
        // R8: valley coinciding with fallback expiry
        expect_period("R8", 5, 2, BLANK + FB - 2, 2, BLANK + FB, 2'b01);
        valley_i = 1'b0;
        step();
        check("R8", int'(start_o), 0);
        // R8: valley coinciding with starter expiry
        expect_period("R8", START - 3, 2, 0, 0, START - 1, 2'b01);
        // R6: arm in one period does not carry into the next
        expect_period("R6", 5, 2, 50, 2, 52, 2'b01);
        expect_period("R6", 0, 0, 0, 0, START, 2'b11);
        // R7: held-high valley counts once
        expect_period("R7", 50, 1000, 0, 0, 52, 2'b01);
        expect_period("R7", 1, 1000, 0, 0, START, 2'b11);
        expect_period("R7", 0, 0, 0, 0, START, 2'b11);
        // R9: disabled, valleys toggle, no starts
        en_i = 1'b0;
        for (int k = 0; k < 300; k++) begin
            valley_i = (k % 7) < 3;
            step();
            check("R9", int'(start_o), 0);
        end
        valley_i = 1'b0;
        en_i = 1'b1;
        expect_period("R9", 60, 2, 0, 0, START, 2'b11);
        // Random phase against the reference model
        for (int k = 0; k < 30000; k++) begin
            if ($urandom_range(0, 999) == 0) en_i = ~en_i;
            else if (!en_i && $urandom_range(0, 19) == 0) en_i = 1'b1;
            if ($urandom_range(0, 29) == 0) valley_i = ~valley_i;
            step();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule